// File: doc/BRIEF.md
# 16-bit Pixel Word Unpacker

This block sits between the frame-buffer fetch path and the colour pipeline of a display controller. Each 32-bit word it receives holds two 16-bit pixels. It emits them one at a time as 24-bit RGB values, 8 bits per channel. Static controls set how the word is read:

- the pixel order within the word;
- the byte order within each pixel;
- the colour layout, either 5-5-5 plus one unused bit, or 5-6-5;
- an optional exchange of the red and blue channels.

The `VARIANT` parameter chooses how the colour layout is selected. With `VARIANT` = 0, a 2-bit external mux code chooses the layout, and one of its codes also forces the red/blue exchange. With `VARIANT` = 1, the mux code has no effect and a single format input chooses the layout. Words come in on a valid/ready port and pixels leave on a valid/ready port. The control inputs must stay constant while a word is being unpacked.

Top module: `px16_unpack`

## Requirements
- R1: After reset no pixel is offered (`pix_valid` = 0) and a word can be taken (`word_ready` = 1).
- R2: A word is taken only when no pixel is pending, or when the last pending pixel leaves in the same cycle. Every word taken yields exactly two pixels, so `word_ready` is low in the cycle after an accept.
- R3: With `byte_swap` = 0 and `pix_swap` = 0, the pixel in bits [15:0] is emitted first and the pixel in bits [31:16] second.
- R4: With `byte_swap` = 0 and `pix_swap` = 1, the pixel in bits [31:16] is emitted first.
- R5: With `byte_swap` = 1, the two bytes of each 16-bit pixel are exchanged before decoding. The pixel order is then [15:0] first, whatever `pix_swap` says.
- R6: In the 5-6-5 layout, pixel bits [4:0] give red, [10:5] give green and [15:11] give blue. The output is `pix_rgb` = {R[7:0], G[7:0], B[7:0]}.
- R7: In the 5-5-5 layout, bits [4:0] give red, [9:5] give green and [14:10] give blue. Bit 15 has no effect.
- R8: When the exchange is active, the red and blue output channels trade places.
- R9: With `VARIANT` = 0, mux code 3 selects 5-6-5 and forces the red/blue exchange, whatever `bgr` says.
- R10: With `VARIANT` = 0, mux codes 0 and 2 select 5-6-5 and code 1 selects 5-5-5. For all three codes, `bgr` = 1 requests the exchange.
- R11: With `VARIANT` = 1, `fmt565` = 1 selects 5-6-5 and 0 selects 5-5-5. `bgr` alone requests the exchange, and `mux_code` has no effect.
- R12: A 5-bit field is widened by shifting it left 3 places and the 6-bit field by shifting it left 2. The vacated low bits are zero.
- R13: While `pix_valid` is high and `pix_ready` is low, the same pixel stays offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_swap | input | 1 | Exchange the bytes within each pixel; overrides `pix_swap` |
| pix_swap | input | 1 | Emit the upper half-word first |
| bgr | input | 1 | Exchange the red and blue channels |
| mux_code | input | 2 | External layout select (VARIANT 0 only) |
| fmt565 | input | 1 | Layout select (VARIANT 1 only): 1 = 5-6-5 |
| word_valid | input | 1 | Input word valid |
| word_ready | output | 1 | Input word can be taken |
| word_data | input | 32 | Input word holding two pixels |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Downstream takes the pixel |
| pix_rgb | output | 24 | Pixel as {R, G, B}, 8 bits each |

## Verification
A wrong pending-pixel count shows up at the handshake within one cycle. It appears as a missing or duplicated pixel, or as `word_ready` rising while a pixel is still pending. A wrong half-word select or a wrong byte exchange changes the very first pixel of the next word. A wrong layout or exchange decode corrupts `pix_rgb` in the same cycle the pixel is offered. The model checks both variants side by side every cycle under random stalls, so any of these faults shows up within a few cycles of the word that exposes it.

// File: rtl/px16_unpack.sv
module px16_unpack #(
  parameter int VARIANT = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_swap,
  input  logic        pix_swap,
  input  logic        bgr,
  input  logic [1:0]  mux_code,
  input  logic        fmt565,
  input  logic        word_valid,
  output logic        word_ready,
  input  logic [31:0] word_data,
  output logic        pix_valid,
  input  logic        pix_ready,
  output logic [23:0] pix_rgb
);
  localparam int HALF = 16;

  logic [31:0]     held;
  logic [1:0]      left;
  logic [HALF-1:0] raw, px;
  logic [4:0]      lo5, hi5;
  logic [7:0]      g8;
  logic            hi_first, use_hi, is565, swap_rb;

  assign pix_valid  = (left != 2'd0);
  assign word_ready = (left == 2'd0) || (left == 2'd1 && pix_ready);

  assign hi_first = pix_swap & ~byte_swap;
  assign use_hi   = (left == 2'd2) ? hi_first : ~hi_first;
  assign raw      = use_hi ? held[31:16] : held[15:0];
  assign px       = byte_swap ? {raw[7:0], raw[15:8]} : raw;

  assign is565   = (VARIANT != 0) ? fmt565 : (mux_code != 2'd1);
  assign swap_rb = (VARIANT == 0 && mux_code == 2'd3) ? 1'b1 : bgr;

  assign lo5 = px[4:0];
  assign hi5 = is565 ? px[15:11] : px[14:10];
  assign g8  = is565 ? {px[10:5], 2'b00} : {px[9:5], 3'b000};

  assign pix_rgb = swap_rb ? {hi5, 3'b000, g8, lo5, 3'b000}
                           : {lo5, 3'b000, g8, hi5, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= '0;
      left <= 2'd0;
    end else if (word_valid && word_ready) begin
      held <= word_data;
      left <= 2'd2;
    end else if (pix_valid && pix_ready) begin
      left <= left - 2'd1;
    end
  end

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> (pix_valid && !word_ready));

  a_r1_empty_means_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> word_ready);

  a_r2_second_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    (left == 2'd2 && pix_ready) |=> (left == 2'd1));

  a_r13_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(held) && $stable(left)));

  a_r12_zero_lsbs: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (pix_rgb[18:16] == 3'd0 && pix_rgb[2:0] == 3'd0 && pix_rgb[9:8] == 2'd0));
endmodule

// File: tb/tb_px16_unpack.sv
module tb_px16_unpack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_swap = 0, pix_swap = 0, bgr = 0, fmt565 = 0;
  logic [1:0]  mux_code = 2'd0;
  logic        word_valid = 0, pix_ready = 0;
  logic [31:0] word_data = '0;
  logic        wr0, wr1, pv0, pv1;
  logic [23:0] rgb0, rgb1;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string cur_req = "R1";
  logic [15:0] q[$];

  always #2 clk = ~clk;

  px16_unpack #(.VARIANT(0)) dut (
    .clk(clk), .rst_n(rst_n), .byte_swap(byte_swap), .pix_swap(pix_swap), .bgr(bgr),
    .mux_code(mux_code), .fmt565(fmt565), .word_valid(word_valid), .word_ready(wr0),
    .word_data(word_data), .pix_valid(pv0), .pix_ready(pix_ready), .pix_rgb(rgb0));

  px16_unpack #(.VARIANT(1)) dut_v1 (
    .clk(clk), .rst_n(rst_n), .byte_swap(byte_swap), .pix_swap(pix_swap), .bgr(bgr),
    .mux_code(mux_code), .fmt565(fmt565), .word_valid(word_valid), .word_ready(wr1),
    .word_data(word_data), .pix_valid(pv1), .pix_ready(pix_ready), .pix_rgb(rgb1));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_pix(input logic [15:0] h, input int variant);
    logic [15:0] v;
    logic [7:0] r, g, b, t;
    bit wide, sw;
    v = byte_swap ? {h[7:0], h[15:8]} : h;
    wide = (variant == 1) ? fmt565 : (mux_code != 2'd1);
    sw = (variant == 0 && mux_code == 2'd3) ? 1'b1 : bgr;
    r = {v[4:0], 3'b000};
    if (wide) begin
      g = {v[10:5], 2'b00};
      b = {v[15:11], 3'b000};
    end else begin
      g = {v[9:5], 3'b000};
      b = {v[14:10], 3'b000};
    end
    if (sw) begin t = r; r = b; b = t; end
    return {r, g, b};
  endfunction

  task automatic step(input bit wv, input bit pr, input logic [31:0] wd);
    bit ev, er;
    @(negedge clk);
    word_valid = wv; pix_ready = pr; word_data = wd;
    #1;
    ev = (q.size() != 0);
    er = (q.size() == 0) || (q.size() == 1 && pr);
    chk(pv0 == ev, "R2 valid v0", {31'd0, pv0}, {31'd0, ev});
    chk(pv1 == ev, "R2 valid v1", {31'd0, pv1}, {31'd0, ev});
    chk(wr0 == er, "R2 ready v0", {31'd0, wr0}, {31'd0, er});
    chk(wr1 == er, "R2 ready v1", {31'd0, wr1}, {31'd0, er});
    if (ev) begin
      chk(rgb0 == ref_pix(q[0], 0), {cur_req, " pixel v0"}, {8'd0, rgb0}, {8'd0, ref_pix(q[0], 0)});
      chk(rgb1 == ref_pix(q[0], 1), {cur_req, " pixel v1"}, {8'd0, rgb1}, {8'd0, ref_pix(q[0], 1)});
    end
    if (ev && pr) void'(q.pop_front());
    if (wv && er) begin
      if (byte_swap || !pix_swap) begin q.push_back(wd[15:0]); q.push_back(wd[31:16]); end
      else begin q.push_back(wd[31:16]); q.push_back(wd[15:0]); end
    end
  endtask

  task automatic phase(input string req, input bit bs, input bit ps, input bit b,
                       input logic [1:0] mc, input bit f, input int words,
                       input int rdy_pct, input bit fixed, input logic [31:0] fd);
    int got = 0;
    @(negedge clk);
    cur_req = req;
    byte_swap = bs; pix_swap = ps; bgr = b; mux_code = mc; fmt565 = f;
    while (got < words) begin
      bit wv = ($urandom_range(99) < 70);
      bit pr = ($urandom_range(99) < rdy_pct);
      logic [31:0] wd = fixed ? fd : $urandom;
      bit take = wv && ((q.size() == 0) || (q.size() == 1 && pr));
      step(wv, pr, wd);
      if (take) got++;
    end
    while (q.size() != 0) step(1'b0, 1'b1, 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL R2: watchdog expired, actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(pv0 == 1'b0 && pv1 == 1'b0, "R1 no pixel after reset", {31'd0, pv0 | pv1}, 32'd0);
    chk(wr0 == 1'b1 && wr1 == 1'b1, "R1 ready after reset", {31'd0, wr0 & wr1}, 32'd1);

    phase("R3 low half first",            0, 0, 0, 2'd0, 1, 30, 80, 0, 0);
    phase("R4 high half first",           0, 1, 0, 2'd0, 1, 30, 80, 0, 0);
    phase("R5 byte swap overrides order", 1, 1, 0, 2'd2, 1, 30, 80, 0, 0);
    phase("R5 byte swap alone",           1, 0, 0, 2'd2, 1, 20, 80, 0, 0);
    phase("R6 565 fields",                0, 0, 0, 2'd2, 1, 20, 90, 1, 32'h07E0_F81F);
    phase("R6 565 random",                0, 0, 0, 2'd2, 1, 30, 70, 0, 0);
    phase("R7 5551 top bit ignored",      0, 0, 0, 2'd1, 0, 20, 90, 1, 32'h8000_7FFF);
    phase("R7 5551 random",               0, 0, 0, 2'd1, 0, 30, 70, 0, 0);
    phase("R8 exchange 565",              0, 0, 1, 2'd0, 1, 30, 70, 0, 0);
    phase("R8 exchange 5551",             0, 1, 1, 2'd1, 0, 30, 70, 0, 0);
    phase("R9 code 3 forces exchange",    0, 0, 0, 2'd3, 1, 30, 70, 0, 0);
    phase("R9 code 3 with bgr",           0, 0, 1, 2'd3, 0, 20, 70, 0, 0);
    phase("R10 code 2 with bgr",          0, 0, 1, 2'd2, 0, 20, 70, 0, 0);
    phase("R10 code 0 plain",             1, 0, 0, 2'd0, 0, 20, 70, 0, 0);
    phase("R11 fmt565 low mux ignored",   0, 0, 0, 2'd3, 0, 30, 70, 0, 0);
    phase("R11 fmt565 high mux ignored",  0, 1, 1, 2'd1, 1, 30, 70, 0, 0);
    phase("R12 all ones widening",        0, 0, 0, 2'd2, 1, 10, 90, 1, 32'hFFFF_FFFF);
    phase("R12 all ones 5551",            0, 0, 1, 2'd1, 0, 10, 90, 1, 32'hFFFF_FFFF);
    phase("R13 heavy stall",              0, 1, 0, 2'd2, 1, 40, 15, 0, 0);
    phase("R2 full throughput",           1, 0, 1, 2'd0, 1, 40, 100, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule